// File: doc/BRIEF.md
# SPI Master With Programmable Inter-Word Gap

This block is an SPI bus master. The host loads a format (word length, clock phase, clock polarity, clock prescale and gap count). It then writes one control/data word per SPI word. Each write carries an active-low chip-select pattern, a hold flag, a gap-enable flag and the data to send. The engine shifts the word out MSB first on `mosi_o`. On the same SCLK edges it shifts a word in from `miso_i`, or from its own `mosi_o` when loopback is on. It returns the received word right-justified on `rd_data_o` with a one-cycle `rd_done_o` strobe.

When the gap-enable flag of a word is set, the engine stays busy for a fixed number of extra module-clock cycles after that word. During those cycles SCLK rests at its idle level and MOSI holds its last bit. The gap lets slow slaves recover between words. The hold flag decides whether the chip select stays asserted between words or is released after the word.

Top module: `spi_wd_master`

## Requirements
- R1: While reset is asserted and afterwards until the first write, `cs_no` is all ones, `wr_ready_o` is 1, `rd_done_o` is 0, `rd_data_o` is 0, `mosi_o` is 0 and `sclk_o` equals `cfg_pol_i`.
- R2: A write is taken at a clock edge where `wr_valid_i` and `wr_ready_o` are both 1. `wr_ready_o` is 0 from the next cycle until the word and any gap after it are finished. While it is 0, `wr_valid_i` is ignored.
- R3: With prescale P and effective length L, each SCLK half-period lasts P+1 module cycles and a word lasts exactly 2·L·(P+1) cycles. Outside a word, SCLK rests at the polarity level.
- R4: With `cfg_phase_i`=1, SCLK is at its idle level in the first half of every bit and leaves it at mid-bit. With `cfg_phase_i`=0, SCLK leaves idle at the start of every bit.
- R5: Data goes out MSB first. Bit L-1 of `wr_data_i` is on `mosi_o` from the first cycle of the word, and each further bit appears at the start of its bit period.
- R6: `miso_i` is sampled in the last cycle of the first half of each bit. The L sampled bits appear right-justified on `rd_data_o`, with upper bits 0, in the cycle after the word's last cycle.
- R7: `rd_done_o` is a single-cycle pulse in the cycle after each word's last cycle.
- R8: A `cfg_len_i` value below 2 acts as 2, and a value above 16 acts as 16.
- R9: `cs_no` takes the written pattern (0 = selected) from the first cycle of the word. In the cycle `rd_done_o` pulses it returns to all ones when the hold flag was 0, and keeps the pattern when the hold flag was 1.
- R10: With the gap flag set, `wr_ready_o` stays 0 for `cfg_dly_i`+2 further cycles after the word. During that time SCLK stays at idle and `mosi_o` keeps the word's last bit.
- R11: With the gap flag clear, `wr_ready_o` is 1 in the same cycle `rd_done_o` pulses, so the next word can start one cycle after the last.
- R12: With `loop_en_i`=1 the received word equals the low L bits of the sent word, regardless of `miso_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | 5 | Word length in bits, used as 2..16 |
| cfg_phase_i | input | 1 | 1: capture on first SCLK edge of a bit; 0: launch on it |
| cfg_pol_i | input | 1 | SCLK idle level |
| cfg_pre_i | input | 8 | Prescale P: half-period is P+1 module cycles |
| cfg_dly_i | input | 6 | Gap count; gap is count+2 module cycles |
| loop_en_i | input | 1 | Route MOSI internally to the receive path |
| wr_valid_i | input | 1 | Control/data write strobe |
| wr_ready_o | output | 1 | Engine can take a write |
| wr_cs_i | input | 4 | Chip-select pattern, active low |
| wr_hold_i | input | 1 | Keep chip select asserted after this word |
| wr_dly_en_i | input | 1 | Insert the gap after this word |
| wr_data_i | input | 16 | Word to send, right-justified |
| rd_data_o | output | 16 | Last received word, right-justified |
| rd_done_o | output | 1 | One-cycle pulse when a word completes |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |

## Verification
Every result is due at a cycle fixed by the format. The word starts one edge after acceptance, and each half-bit takes P+1 cycles. The received word and its strobe arrive one edge after the 2·L·(P+1)-th cycle of the word. Ready returns either then or `cfg_dly_i`+2 edges later. The bench keeps a time-indexed behavioural model: it computes the SCLK level and MOSI bit from the elapsed cycle count and samples `miso_i` at the same instant the design does. It compares every output at each falling edge, while all stimulus changes 2 ns after the rising edge. Directed checks also count busy cycles per word to confirm word length, clamping, gap length and back-to-back issue.

// File: rtl/spi_wd_pkg.sv
package spi_wd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } spi_st_e;
endpackage

// File: rtl/spi_wd_baud.sv
module spi_wd_baud #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assert_half_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= pre_i));
endmodule

// File: rtl/spi_wd_shreg.sv
module spi_wd_shreg #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0]  msb_idx;

  assign msb_idx = IDX_W'(len_i - LEN_W'(1));
  assign sdo_o   = tx_q[msb_idx];
  assign rx_o    = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_data_i;
      rx_q <= '0;
    end else begin
      if (shift_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (cap_i)   rx_q <= {rx_q[DATA_W-2:0], sdi_i};
    end
  end

  assert_mosi_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sdo_o));
endmodule

// File: rtl/spi_wd_gap.sv
module spi_wd_gap #(
  parameter int DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             expire_o
);
  logic [DLY_W:0] cnt_q;
  logic [DLY_W:0] last_c;

  // gap spans dly+2 cycles: count 0..dly+1
  assign last_c   = {1'b0, dly_i} + 1'b1;
  assign expire_o = run_i && (cnt_q == last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assert_gap_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_c));
endmodule

// File: rtl/spi_wd_master.sv
module spi_wd_master
  import spi_wd_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int CS_N   = 4,
  parameter  int PRE_W  = 8,
  parameter  int DLY_W  = 6,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_phase_i,
  input  logic              cfg_pol_i,
  input  logic [PRE_W-1:0]  cfg_pre_i,
  input  logic [DLY_W-1:0]  cfg_dly_i,
  input  logic              loop_en_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [CS_N-1:0]   wr_cs_i,
  input  logic              wr_hold_i,
  input  logic              wr_dly_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_N-1:0]   cs_no
);
  localparam int HIDX_W = LEN_W + 1;

  spi_st_e            state_q;
  logic [LEN_W-1:0]   len_q, len_c;
  logic [PRE_W-1:0]   pre_q;
  logic [DLY_W-1:0]   dly_q;
  logic               phase_q, pol_q, hold_q, dlyen_q;
  logic [CS_N-1:0]    cs_q;
  logic [HIDX_W-1:0]  hidx_q, last_h;
  logic               accept, tick, last, cap, shift, finish, gap_done, sdi;
  logic [DATA_W-1:0]  rx_w;

  always_comb begin
    len_c = cfg_len_i;
    if (cfg_len_i < LEN_W'(2))           len_c = LEN_W'(2);
    else if (cfg_len_i > LEN_W'(DATA_W)) len_c = LEN_W'(DATA_W);
  end

  assign wr_ready_o = (state_q == ST_IDLE);
  assign accept     = wr_valid_i && wr_ready_o;
  assign last_h     = {len_q, 1'b0} - 1'b1;
  assign last       = (hidx_q == last_h);
  // even half ends: sample; odd half ends: next bit
  assign cap        = tick && !last && !hidx_q[0];
  assign shift      = tick && !last &&  hidx_q[0];
  assign finish     = tick && last;
  assign sdi        = loop_en_i ? mosi_o : miso_i;
  assign cs_no      = cs_q;

  always_comb begin
    unique case (state_q)
      ST_SHIFT: sclk_o = pol_q ^ hidx_q[0] ^ ~phase_q;
      ST_GAP:   sclk_o = pol_q;
      default:  sclk_o = cfg_pol_i;
    endcase
  end

  spi_wd_baud #(.PRE_W(PRE_W)) u_baud (
    .clk_i, .rst_ni,
    .run_i  (state_q == ST_SHIFT),
    .pre_i  (pre_q),
    .tick_o (tick)
  );

  spi_wd_shreg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shreg (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .load_data_i (wr_data_i),
    .len_i       (len_q),
    .shift_i     (shift),
    .cap_i       (cap),
    .sdi_i       (sdi),
    .sdo_o       (mosi_o),
    .rx_o        (rx_w)
  );

  spi_wd_gap #(.DLY_W(DLY_W)) u_gap (
    .clk_i, .rst_ni,
    .run_i    (state_q == ST_GAP),
    .dly_i    (dly_q),
    .expire_o (gap_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      len_q     <= LEN_W'(2);
      pre_q     <= '0;
      dly_q     <= '0;
      phase_q   <= 1'b0;
      pol_q     <= 1'b0;
      hold_q    <= 1'b0;
      dlyen_q   <= 1'b0;
      cs_q      <= '1;
      hidx_q    <= '0;
      rd_data_o <= '0;
      rd_done_o <= 1'b0;
    end else begin
      rd_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SHIFT;
          len_q   <= len_c;
          pre_q   <= cfg_pre_i;
          dly_q   <= cfg_dly_i;
          phase_q <= cfg_phase_i;
          pol_q   <= cfg_pol_i;
          hold_q  <= wr_hold_i;
          dlyen_q <= wr_dly_en_i;
          cs_q    <= wr_cs_i;
          hidx_q  <= '0;
        end
        ST_SHIFT: if (finish) begin
          state_q   <= dlyen_q ? ST_GAP : ST_IDLE;
          rd_data_o <= rx_w;
          rd_done_o <= 1'b1;
          if (!hold_q) cs_q <= '1;
        end else if (tick) begin
          hidx_q <= hidx_q + 1'b1;
        end
        ST_GAP: if (gap_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && $past(state_q) == ST_IDLE) |-> $past(wr_valid_i));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);

  assert_cs_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_o && !hold_q) |-> (&cs_no));

  assert_gap_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && $past(state_q) == ST_GAP) |-> ($stable(sclk_o) && $stable(mosi_o)));

  assert_gap_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && $past(state_q) == ST_SHIFT) |-> $past(dlyen_q));
endmodule

// File: tb/sim_spi_wd_master.sv
module sim_spi_wd_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic        cfg_phase = 1'b1, cfg_pol = 1'b0, loop_en = 1'b0;
  logic [7:0]  cfg_pre = 8'd1;
  logic [5:0]  cfg_dly = 6'd0;
  logic        wr_valid = 1'b0, wr_hold = 1'b0, wr_dly_en = 1'b0, miso = 1'b0;
  logic [3:0]  wr_cs = 4'hF;
  logic [15:0] wr_data = '0;
  logic        wr_ready, rd_done, sclk, mosi;
  logic [15:0] rd_data;
  logic [3:0]  cs_n;

  int total = 0, bad = 0;
  bit fin = 0;

  always #5 clk = ~clk;

  spi_wd_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_len_i(cfg_len), .cfg_phase_i(cfg_phase),
    .cfg_pol_i(cfg_pol), .cfg_pre_i(cfg_pre), .cfg_dly_i(cfg_dly), .loop_en_i(loop_en),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_cs_i(wr_cs), .wr_hold_i(wr_hold),
    .wr_dly_en_i(wr_dly_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .rd_done_o(rd_done),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: elapsed-cycle model
  int m_st = 0, m_t = 0, m_g = 0, m_L = 2, m_H = 1, m_dly = 0, m_rx = 0;
  bit m_ph = 0, m_pol = 0, m_hold = 0, m_den = 0, m_done = 0, m_mosi = 0;
  logic [15:0] m_word = '0, m_rd = '0;
  logic [3:0]  m_cs = 4'hF;

  function automatic int clampf(input int l);
    return (l < 2) ? 2 : (l > 16) ? 16 : l;
  endfunction

  function automatic bit e_mosi();
    if (m_st == 1) return m_word[m_L - 1 - (m_t / m_H) / 2];
    return m_mosi;
  endfunction

  function automatic bit e_sclk();
    if (m_st == 1) return m_pol ^ (((m_t / m_H) % 2) == 1) ^ !m_ph;
    if (m_st == 0) return cfg_pol;
    return m_pol;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st = 0; m_cs = 4'hF; m_done = 0; m_rd = '0; m_mosi = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (wr_valid) begin
          m_L = clampf(int'(cfg_len)); m_H = int'(cfg_pre) + 1; m_ph = cfg_phase;
          m_pol = cfg_pol; m_dly = int'(cfg_dly); m_hold = wr_hold; m_den = wr_dly_en;
          m_word = wr_data; m_cs = wr_cs; m_t = 0; m_rx = 0; m_st = 1;
        end
        1: begin
          if ((m_t % m_H) == m_H - 1 && ((m_t / m_H) % 2) == 0)
            m_rx = (m_rx << 1) | int'(loop_en ? e_mosi() : miso);
          m_t++;
          if (m_t == 2 * m_L * m_H) begin
            m_done = 1; m_rd = 16'(m_rx); m_mosi = m_word[0];
            if (!m_hold) m_cs = 4'hF;
            m_g = 0; m_st = m_den ? 2 : 0;
          end
        end
        default: begin
          m_g++;
          if (m_g == m_dly + 2) m_st = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      chk(sclk == e_sclk(), "R3/R4 sclk", sclk, e_sclk());
      chk(mosi == e_mosi(), "R5 mosi", mosi, e_mosi());
      chk(cs_n == m_cs, "R9 cs_n", cs_n, m_cs);
      chk(wr_ready == (m_st == 0), "R2 ready", wr_ready, m_st == 0);
      chk(rd_done == m_done, "R7 done", rd_done, m_done);
      chk(rd_data == m_rd, "R6 rd_data", rd_data, m_rd);
    end
  end

  // random slave data, changed away from the edge
  always @(posedge clk) #2 miso <= 1'($urandom);

  task automatic xfer(input logic [15:0] d, input logic [3:0] cs, input bit hold,
                      input bit den, input int eff_len, input string tag);
    int n, exp;
    while (!wr_ready) begin @(posedge clk); #2; end
    wr_data = d; wr_cs = cs; wr_hold = hold; wr_dly_en = den; wr_valid = 1'b1;
    @(posedge clk); #2;
    wr_valid = 1'b0;
    // R2: a write held while busy must not start another word
    wr_data = ~d; wr_valid = 1'b1;
    n = 0;
    while (!wr_ready) begin @(posedge clk); #2; n++; end
    wr_valid = 1'b0;
    exp = 2 * eff_len * (int'(cfg_pre) + 1) + (den ? int'(cfg_dly) + 2 : 0);
    chk(n == exp, tag, n, exp);
    if (!den) chk(rd_done == 1'b1, "R11 ready with done", rd_done, 1);
    if (loop_en)
      chk(rd_data == (d & 16'((32'h1 << eff_len) - 1)), "R12 loopback",
          rd_data, d & 16'((32'h1 << eff_len) - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF, "R1 cs", cs_n, 15);
    chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    chk(rd_done == 1'b0, "R1 done", rd_done, 0);
    chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(sclk == cfg_pol, "R1 sclk", sclk, cfg_pol);
    rst_ni = 1'b1;
    @(posedge clk); #2;
    xfer(16'h00A5, 4'b1110, 0, 0, 8, "R3 len8 pre1");
    xfer(16'h003C, 4'b1101, 1, 0, 8, "R9 hold back-to-back");
    xfer(16'h0081, 4'b1101, 0, 0, 8, "R11 no gap");
    cfg_dly = 6'd5;
    xfer(16'h00F0, 4'b1011, 1, 1, 8, "R10 gap dly5");
    cfg_dly = 6'd0;
    xfer(16'h0055, 4'b1011, 0, 1, 8, "R10 gap dly0");
    cfg_len = 5'd12; cfg_pre = 8'd0; cfg_phase = 1'b0; cfg_pol = 1'b1;
    xfer(16'h0ABC, 4'b0111, 0, 0, 12, "R4 phase0 pol1");
    cfg_len = 5'd16; cfg_pre = 8'd2; cfg_phase = 1'b1;
    xfer(16'hC3A5, 4'b1110, 0, 0, 16, "R5 len16");
    cfg_len = 5'd1; cfg_pre = 8'd0;
    xfer(16'h0002, 4'b1110, 0, 0, 2, "R8 clamp low");
    cfg_len = 5'd31;
    xfer(16'h8001, 4'b1110, 0, 0, 16, "R8 clamp high");
    loop_en = 1'b1; cfg_len = 5'd10; cfg_pre = 8'd1; cfg_phase = 1'b0; cfg_pol = 1'b0;
    xfer(16'h02D6, 4'b1101, 1, 0, 10, "R12 loop phase0");
    cfg_phase = 1'b1; cfg_dly = 6'd3;
    xfer(16'h0319, 4'b1101, 0, 1, 10, "R12 loop phase1 gap");
    loop_en = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule